// File: doc/BRIEF.md
# Two-Stage Shift-Register Frame Writer

This block drives a pair of daisy-chained serial-in/parallel-out shift registers. Each of these registers has an output storage latch. A typical use is a multiplexed seven-segment display: one register holds the segment pattern and the other holds the digit-select pattern. The block takes a segment byte and a select byte together with a one-cycle start request. It shifts both bytes out as one frame on a serial data line, timed by a serial clock derived from the system clock. It then strobes a separate latch line once, so that both registers present their new contents at the same moment. A one-cycle done pulse closes the transfer.

The segment byte leaves first. After the full frame it therefore sits in the register at the far end of the chain. The select byte stays in the near register. The serial clock idles low and the data line changes only as the serial clock falls, so data is steady at every rising edge. Requests that arrive while a frame is still in flight are dropped.

`CLK_DIV` sets the number of system clocks per serial bit and must be even. `BYTE_W` sets the width of each byte. `LATCH_CYCLES` sets the strobe width.

Top module: `sr_pair_writer`

## Requirements
- R1: The frame is sent most significant bit first, as `seg_byte` followed by `sel_byte` (`{seg_byte, sel_byte}`), so the segment byte ends in the far register of the chain.
- R2: For each bit, `sclk` is low for `CLK_DIV/2` system clocks and then high for `CLK_DIV/2` system clocks, giving a serial clock of the system clock divided by `CLK_DIV` (default 16).
- R3: `sdo` never changes while `sclk` is high; it takes each new bit in the same cycle in which `sclk` falls.
- R4: Each transfer has exactly `2*BYTE_W` rising edges of `sclk`.
- R5: `latch` idles low. It rises one system clock after the last falling edge of `sclk` and stays high for exactly `LATCH_CYCLES` system clocks, and `sclk` stays low throughout.
- R6: `done` is high for exactly one system clock, in the cycle immediately after `latch` falls, and at no other time.
- R7: `start` is taken only when the block is idle. A request made during shifting, latching or the done cycle is ignored: it produces no extra serial clocks, no extra frame and no extra done pulse.
- R8: Synchronous active-high `rst` forces `sclk`, `sdo`, `latch` and `done` low and abandons any transfer in progress.
- R9: After a transfer, `sdo`, `sclk` and `latch` are all low until the next accepted start.
- R10: `done` rises at the clock edge that comes `2*BYTE_W*CLK_DIV + LATCH_CYCLES + 1` edges after the edge that sampled the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request |
| seg_byte | input | BYTE_W | Segment pattern, sent first |
| sel_byte | input | BYTE_W | Digit-select pattern, sent second |
| sdo | output | 1 | Serial data to the first register in the chain |
| sclk | output | 1 | Serial shift clock, idle low |
| latch | output | 1 | Storage-latch strobe for both registers |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `CLK_DIV=4`, `BYTE_W=8` and `LATCH_CYCLES=3`. The short divider keeps every frame to a few dozen cycles, so several frames, a mid-frame reset and the late-request cases all fit in a short run while the low/high phase counting is still exercised. A strobe width of three makes the latch-width counter, and the placement of done after it, observable; a width of one would hide both. The scoreboard holds each queued frame and its predicted done cycle. It compares them with the bits captured at each rising `sclk` and with the cycle in which done appears.

// File: rtl/srw_pkg.sv
package srw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SHIFT  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_STROBE = 3'd3,
    ST_DONE   = 3'd4
  } srw_state_e;

endpackage

// File: rtl/srw_bit_timer.sv
module srw_bit_timer #(
  parameter int CLK_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic bit_end
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          rise_now;

  assign rise_now = run && (cnt == CW'(HALF - 1));
  assign bit_end  = run && (cnt == CW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      if (bit_end) cnt <= '0;
      else         cnt <= cnt + 1'b1;
      if (rise_now)     sclk <= 1'b1;
      else if (bit_end) sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/srw_frame_shifter.sv
module srw_frame_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               step,
  output logic               sdo,
  output logic               last
);
  localparam int BW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sr;
  logic [BW-1:0]      bc;

  assign sdo  = sr[FRAME_W-1];
  assign last = (bc == BW'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
      bc <= '0;
    end else if (load) begin
      sr <= frame;
      bc <= '0;
    end else if (step) begin
      if (last) begin
        sr <= '0;
        bc <= '0;
      end else begin
        sr <= {sr[FRAME_W-2:0], 1'b0};
        bc <= bc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srw_latch_pulse.sv
module srw_latch_pulse #(
  parameter int LATCH_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic latch,
  output logic fin
);
  localparam int LW = (LATCH_CYCLES > 1) ? $clog2(LATCH_CYCLES) : 1;

  logic [LW-1:0] lc;

  assign fin = latch && (lc == LW'(LATCH_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= 1'b0;
      lc    <= '0;
    end else if (fire) begin
      latch <= 1'b1;
      lc    <= '0;
    end else if (latch) begin
      if (fin) latch <= 1'b0;
      else     lc    <= lc + 1'b1;
    end
  end
endmodule

// File: rtl/sr_pair_writer.sv
module sr_pair_writer #(
  parameter int BYTE_W       = 8,
  parameter int CLK_DIV      = 16,
  parameter int LATCH_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] seg_byte,
  input  logic [BYTE_W-1:0] sel_byte,
  output logic              sdo,
  output logic              sclk,
  output logic              latch,
  output logic              done
);
  import srw_pkg::*;

  localparam int FRAME_W = 2 * BYTE_W;

  srw_state_e state, state_nx;
  logic       load, run, bit_end, last_bit, fire, fin;

  assign load = (state == ST_IDLE) && start;
  assign run  = (state == ST_SHIFT);
  assign fire = (state == ST_SETTLE);

  srw_bit_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .sclk    (sclk),
    .bit_end (bit_end)
  );

  srw_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .frame ({seg_byte, sel_byte}),
    .step  (bit_end),
    .sdo   (sdo),
    .last  (last_bit)
  );

  srw_latch_pulse #(.LATCH_CYCLES(LATCH_CYCLES)) u_strobe (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .latch (latch),
    .fin   (fin)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (start) state_nx = ST_SHIFT;
      ST_SHIFT:  if (bit_end && last_bit) state_nx = ST_SETTLE;
      ST_SETTLE: state_nx = ST_STROBE;
      ST_STROBE: if (fin) state_nx = ST_DONE;
      ST_DONE:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= (state == ST_STROBE) && fin;
    end
  end
endmodule

// File: rtl/srw_checker.sv
module srw_checker (
  input logic clk,
  input logic rst,
  input logic sdo,
  input logic sclk,
  input logic latch,
  input logic done
);
  // R3: data held steady across the high phase of the serial clock
  a_r3_sdo_stable_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R5: strobe rises only once the serial clock has been low a full cycle
  a_r5_latch_after_sclk_low: assert property (@(posedge clk) disable iff (rst)
    $rose(latch) |-> (!sclk && !$past(sclk)));

  // R5: no serial clock activity during the strobe
  a_r5_no_sclk_in_strobe: assert property (@(posedge clk) disable iff (rst)
    latch |-> !sclk);

  // R6: done only right after the strobe falls
  a_r6_done_after_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(latch));

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: data line already back low while latching
  a_r9_sdo_low_in_strobe: assert property (@(posedge clk) disable iff (rst)
    latch |-> !sdo);
endmodule

bind sr_pair_writer srw_checker u_srw_checker (
  .clk   (clk),
  .rst   (rst),
  .sdo   (sdo),
  .sclk  (sclk),
  .latch (latch),
  .done  (done)
);

// File: tb/tb_sr_pair_writer.sv
module tb_sr_pair_writer;
  localparam int BW   = 8;
  localparam int DIV  = 4;
  localparam int LC   = 3;
  localparam int FW   = 2 * BW;
  localparam int HALF = DIV / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [BW-1:0] seg_byte = '0;
  logic [BW-1:0] sel_byte = '0;
  logic          sdo, sclk, latch, done;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;

  logic [FW-1:0] exp_frames[$];
  int            exp_done[$];

  sr_pair_writer #(.BYTE_W(BW), .CLK_DIV(DIV), .LATCH_CYCLES(LC)) dut (
    .clk(clk), .rst(rst), .start(start), .seg_byte(seg_byte),
    .sel_byte(sel_byte), .sdo(sdo), .sclk(sclk), .latch(latch), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: pulse start and queue the expected frame and done cycle
  task automatic send(input logic [BW-1:0] s, input logic [BW-1:0] d, input bit push);
    @(negedge clk);
    seg_byte = s;
    sel_byte = d;
    start    = 1'b1;
    if (push) begin
      exp_frames.push_back({s, d});
      exp_done.push_back(cyc + 1 + FW * DIV + LC + 1);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input bit poke);
    while (!done) @(negedge clk);
    if (poke) begin
      start = 1'b1; seg_byte = 8'h77; sel_byte = 8'h66;  // R7 request during done cycle
    end
    @(negedge clk);
    start = 1'b0;
    chk(sclk == 1'b0 && latch == 1'b0 && sdo == 1'b0, "R9 idle lines after transfer",
        {sclk, latch, sdo}, 0);
    chk(done == 1'b0, "R6 done single cycle", done, 0);
    if (poke) begin
      for (int i = 0; i < 3 * DIV; i++) begin
        @(negedge clk);
        chk(sclk == 1'b0 && latch == 1'b0, "R7 late request ignored", {sclk, latch}, 0);
      end
    end
  endtask

  // monitor / scoreboard
  logic          p_sclk, p_latch, p_sdo;
  int            rise_cnt, hi_len, lo_len, l_len;
  logic [FW-1:0] got;

  always @(negedge clk) begin
    if (rst) begin
      p_sclk = 0; p_latch = 0; p_sdo = 0;
      rise_cnt = 0; hi_len = 0; lo_len = 0; l_len = 0; got = '0;
    end else begin
      if (sclk && !p_sclk) begin
        if (rise_cnt > 0) chk(lo_len == HALF, "R2 low phase length", lo_len, HALF);
        got = {got[FW-2:0], sdo};
        rise_cnt++;
        hi_len = 1;
      end else if (sclk) begin
        chk(sdo == p_sdo, "R3 sdo stable while sclk high", sdo, p_sdo);
        hi_len++;
      end
      if (!sclk && p_sclk) begin
        chk(hi_len == HALF, "R2 high phase length", hi_len, HALF);
        lo_len = 1;
      end else if (!sclk) lo_len++;

      if (latch && !p_latch) begin
        chk(rise_cnt == FW, "R4 rising edges per frame", rise_cnt, FW);
        chk(!sclk && !p_sclk, "R5 latch after sclk low", {p_sclk, sclk}, 0);
        if (exp_frames.size() == 0) chk(0, "R7 unexpected frame", got, 0);
        else begin
          logic [FW-1:0] e;
          e = exp_frames.pop_front();
          chk(got == e, "R1 frame order", got, e);
        end
        rise_cnt = 0;
        l_len = 1;
      end else if (latch) l_len++;

      if (!latch && p_latch) begin
        chk(l_len == LC, "R5 latch width", l_len, LC);
        chk(done == 1'b1, "R6 done after latch fall", done, 1);
        if (exp_done.size() == 0) chk(0, "R7 unexpected done", cyc, 0);
        else begin
          int e;
          e = exp_done.pop_front();
          chk(cyc == e, "R10 done latency", cyc, e);
        end
      end else if (done) chk(0, "R6 stray done", done, 0);

      p_sclk = sclk; p_latch = latch; p_sdo = sdo;
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk({sclk, sdo, latch, done} == 4'b0, "R8 reset outputs", {sclk, sdo, latch, done}, 0);
    rst = 1'b0;
    @(negedge clk);

    send(8'hA5, 8'h01, 1); wait_done(0);
    send(8'hFF, 8'h80, 1); wait_done(0);
    send(8'h00, 8'h08, 1); wait_done(0);
    send(8'h3C, 8'hC3, 1); wait_done(0);

    // R7: request in mid-transfer, then one during the done cycle
    send(8'h96, 8'h02, 1);
    repeat (10) @(negedge clk);
    send(8'h11, 8'h22, 0);
    wait_done(1);

    // R8: reset abandons a transfer in flight
    send(8'h5A, 8'h04, 1);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    exp_frames.delete();
    exp_done.delete();
    repeat (2) @(negedge clk);
    chk({sclk, sdo, latch, done} == 4'b0, "R8 reset mid transfer", {sclk, sdo, latch, done}, 0);
    rst = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    chk(sclk == 1'b0 && latch == 1'b0, "R8 stays idle after reset", {sclk, latch}, 0);

    send(8'h12, 8'h34, 1); wait_done(0);

    chk(exp_frames.size() == 0, "R7 all frames latched once", exp_frames.size(), 0);
    chk(exp_done.size() == 0, "R6 all done pulses seen", exp_done.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule